// File: doc/BRIEF.md
# FSM State Transition Trace Logger

This block sits beside one finite state machine and keeps a short history of where that machine has been, for debug after the chip is built. It samples the machine's state code on every clock. When the sampled code differs from the one held from the previous cycle, it writes one trace word into a private FIFO. The word holds the code of the state that was just left and how many clock cycles the machine spent there.

A debug reader drains the history one word per read strobe. Status outputs show empty, full, the number of stored words, and a sticky flag that records lost transitions. Each monitored machine gets its own instance, with its own storage.

Top module: `fsm_trace_logger`

## Requirements
- R1: A trace word is pushed at a rising edge exactly when the sampled `state_i` differs from the value sampled at the previous edge. An unchanged state pushes nothing.
- R2: A trace word is `{state, dwell}`. Bits [STATE_W+CNT_W-1:CNT_W] hold the departed state code. Bits [CNT_W-1:0] hold the number of rising edges at which that state was sampled.
- R3: The state sampled at the first edge after reset produces no word while it is held. Its word is pushed when it is left, and its dwell count includes that first edge.
- R4: When `rd_i` is high at an edge and the FIFO is not empty, the oldest word is removed. That word appears on `rd_data_o` after that edge and stays there until the next accepted read. Words leave in the order they were written.
- R5: The dwell field saturates at all ones (255 by default) and does not wrap. After a state change, counting restarts at 1 for the new state.
- R6: A transition that arrives while the FIFO is full is dropped. It sets `overflow_o`, which stays high until reset.
- R7: A push and a pop at the same edge, with the FIFO neither empty nor full, both take effect and leave `count_o` unchanged.
- R8: `count_o` gives the number of stored words, `empty_o` is high exactly when it is 0, and `full_o` is high exactly when it equals DEPTH (8 by default).
- R9: A read strobe while the FIFO is empty is ignored. `rd_data_o` and `count_o` do not change.
- R10: While `rst_ni` is low, `empty_o`=1, `full_o`=0, `count_o`=0, `overflow_o`=0 and `rd_data_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| state_i | input | STATE_W | State code of the observed machine |
| rd_i | input | 1 | Read strobe; pops one word |
| rd_data_o | output | STATE_W+CNT_W | Last word popped |
| empty_o | output | 1 | No words stored |
| full_o | output | 1 | DEPTH words stored |
| count_o | output | $clog2(DEPTH+1) | Number of stored words |
| overflow_o | output | 1 | Sticky: a transition was dropped |

## Verification
A wrong held state code shows up either as an extra trace word or as a missing one. This is visible in `count_o` at the edge of the next sample. A dwell counter that misses its restart or its saturation stays hidden until that word is read out, so the bench reads back every word and compares it field by field. A wrong FIFO pointer or occupancy shows within one read or write: `count_o`, the flags or the word order go wrong at once.

// File: rtl/fsm_trace_pkg.sv
package fsm_trace_pkg;
  localparam int unsigned DEF_STATE_W = 4;
  localparam int unsigned DEF_CNT_W   = 8;
  localparam int unsigned DEF_DEPTH   = 8;
endpackage

// File: rtl/trace_dwell_tracker.sv
module trace_dwell_tracker #(
  parameter int unsigned STATE_W = 4,
  parameter int unsigned CNT_W   = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [STATE_W-1:0]       state_i,
  output logic                     push_o,
  output logic [STATE_W+CNT_W-1:0] entry_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic               armed_q;
  logic [STATE_W-1:0] prev_q;
  logic [CNT_W-1:0]   dwell_q;

  assign push_o  = armed_q && (state_i != prev_q);
  assign entry_o = {prev_q, dwell_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      prev_q  <= '0;
      dwell_q <= '0;
    end else if (!armed_q || push_o) begin
      // first sample after reset or a new state: count starts at this edge
      armed_q <= 1'b1;
      prev_q  <= state_i;
      dwell_q <= CNT_ONE;
    end else if (dwell_q != CNT_MAX) begin
      dwell_q <= dwell_q + CNT_ONE;
    end
  end

  a_r5_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> dwell_q == CNT_ONE);
  a_r5_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !push_o && dwell_q == CNT_MAX) |=> dwell_q == CNT_MAX);
  a_r1_hold_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !push_o) |=> $stable(prev_q));
endmodule

// File: rtl/trace_fifo.sv
module trace_fifo #(
  parameter int unsigned WIDTH = 12,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CW-1:0]    count_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [CW-1:0]    count_q;
  logic [WIDTH-1:0] rdat_q;
  logic             do_wr, do_rd;

  assign empty_o   = (count_q == '0);
  assign full_o    = (count_q == FULL);
  assign count_o   = count_q;
  assign rd_data_o = rdat_q;
  assign do_wr     = wr_i && !full_o;
  assign do_rd     = rd_i && !empty_o;

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
      rdat_q  <= '0;
    end else begin
      if (do_wr) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + AW'(1);
      if (do_rd) begin
        rdat_q <= mem_q[rptr_q];
        rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + AW'(1);
      end
      case ({do_wr, do_rd})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  a_r8_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= FULL);
  a_r9_empty_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && empty_o) |=> ($stable(rd_data_o) && $stable(count_o)));
  a_r6_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !rd_i) |=> full_o);
  a_r7_push_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rd_i && !empty_o && !full_o) |=> $stable(count_o));
  a_r8_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o));
endmodule

// File: rtl/fsm_trace_logger.sv
module fsm_trace_logger
  import fsm_trace_pkg::*;
#(
  parameter int unsigned STATE_W = DEF_STATE_W,
  parameter int unsigned CNT_W   = DEF_CNT_W,
  parameter int unsigned DEPTH   = DEF_DEPTH,
  localparam int unsigned EW     = STATE_W + CNT_W,
  localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STATE_W-1:0] state_i,
  input  logic               rd_i,
  output logic [EW-1:0]      rd_data_o,
  output logic               empty_o,
  output logic               full_o,
  output logic [CW-1:0]      count_o,
  output logic               overflow_o
);
  logic          push;
  logic [EW-1:0] entry;
  logic          ovf_q;

  trace_dwell_tracker #(.STATE_W(STATE_W), .CNT_W(CNT_W)) u_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (state_i),
    .push_o  (push),
    .entry_o (entry)
  );

  trace_fifo #(.WIDTH(EW), .DEPTH(DEPTH)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (push),
    .wr_data_i (entry),
    .rd_i      (rd_i),
    .rd_data_o (rd_data_o),
    .empty_o   (empty_o),
    .full_o    (full_o),
    .count_o   (count_o)
  );

  // a dropped transition is remembered until reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ovf_q <= 1'b0;
    else if (push && full_o)  ovf_q <= 1'b1;
  end
  assign overflow_o = ovf_q;

  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  a_r6_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && full_o) |=> overflow_o);
  a_r1_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push && !rd_i) |=> $stable(count_o));
endmodule

// File: tb/fsm_trace_logger_tb_top.sv
module fsm_trace_logger_tb_top;
  localparam int unsigned SW = 4;
  localparam int unsigned CWD = 8;
  localparam int unsigned DEPTH = 8;
  localparam int unsigned EW = SW + CWD;
  localparam int unsigned QW = $clog2(DEPTH + 1);

  // {state, hold cycles}
  localparam int NVEC = 5;
  localparam logic [11:0] VEC [NVEC] = '{
    {4'd3, 8'd2}, {4'd7, 8'd1}, {4'd2, 8'd4}, {4'd9, 8'd3}, {4'd5, 8'd6}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [SW-1:0] state = '0;
  logic rd = 1'b0;
  logic [EW-1:0] rdata;
  logic empty, full, ovf;
  logic [QW-1:0] cnt;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  fsm_trace_logger dut_i (
    .clk_i(clk), .rst_ni(rst_n), .state_i(state), .rd_i(rd),
    .rd_data_o(rdata), .empty_o(empty), .full_o(full),
    .count_o(cnt), .overflow_o(ovf)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [SW-1:0] s);
    @(negedge clk);
    rst_n = 1'b0; state = s; rd = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // present s, let it be sampled at n edges
  task automatic hold(input logic [SW-1:0] s, input int n);
    state = s;
    repeat (n) @(negedge clk);
  endtask

  task automatic pop();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R10 reset values
    @(negedge clk);
    check("R10 empty", 32'(empty), 1);
    check("R10 full", 32'(full), 0);
    check("R10 count", 32'(cnt), 0);
    check("R10 ovf", 32'(ovf), 0);
    check("R10 rdata", 32'(rdata), 0);

    // table walk: R1 R2 R3 R4
    do_reset(VEC[0][11:8]);
    for (int i = 0; i < NVEC; i++) begin
      hold(VEC[i][11:8], int'(VEC[i][7:0]));
      if (i == 0) check("R3 first state no entry", 32'(cnt), 0);
    end
    check("R1 entries after walk", 32'(cnt), NVEC - 1);
    hold(4'd5, 3);
    check("R1 no entry while stable", 32'(cnt), NVEC - 1);
    for (int i = 0; i < NVEC - 1; i++) begin
      pop();
      check("R2 R4 entry word", 32'(rdata), 32'(VEC[i]));
    end
    check("R8 empty after drain", 32'(empty), 1);

    // R9 empty read ignored
    pop();
    check("R9 rdata unchanged", 32'(rdata), 32'(VEC[NVEC-2]));
    check("R9 count unchanged", 32'(cnt), 0);

    // R5 saturation and restart
    do_reset(4'd1);
    hold(4'd1, 300);
    hold(4'd2, 1);
    hold(4'd3, 1);
    pop();
    check("R5 saturated dwell", 32'(rdata), {20'd0, 4'd1, 8'hff});
    pop();
    check("R5 restart at 1", 32'(rdata), {20'd0, 4'd2, 8'd1});

    // R6 R8 overflow: 10 transitions into 8 slots
    do_reset(4'd1);
    for (int s = 1; s <= 11; s++) hold(4'(s), 1);
    check("R8 full", 32'(full), 1);
    check("R8 count at full", 32'(cnt), DEPTH);
    check("R6 overflow set", 32'(ovf), 1);
    pop();
    check("R6 overflow sticky", 32'(ovf), 1);
    check("R8 not full after pop", 32'(full), 0);
    check("R6 oldest kept", 32'(rdata), {20'd0, 4'd1, 8'd1});
    for (int k = 2; k <= 8; k++) begin
      pop();
      check("R6 R4 order", 32'(rdata), {20'd0, 4'(k), 8'd1});
    end
    check("R6 dropped not stored", 32'(empty), 1);
    check("R6 still set", 32'(ovf), 1);

    // R7 simultaneous push and pop
    do_reset(4'd1);
    hold(4'd1, 1);
    hold(4'd2, 1);
    hold(4'd3, 1);
    check("R7 setup count", 32'(cnt), 2);
    state = 4'd4; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    check("R7 count kept", 32'(cnt), 2);
    check("R7 popped word", 32'(rdata), {20'd0, 4'd1, 8'd1});
    pop();
    check("R7 next word", 32'(rdata), {20'd0, 4'd2, 8'd1});
    pop();
    check("R7 pushed word", 32'(rdata), {20'd0, 4'd3, 8'd1});
    check("R6 cleared by reset", 32'(ovf), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule